// File: doc/BRIEF.md
# Receive Frame Filter with Per-Reason Drop Counters

This block sits in a receive path after the PHY has delivered a frame. For each frame it gets a summary of that frame: whether the checksum failed, whether the frame is a control frame, its length in bytes, and its 48-bit receiver address. From these it decides whether the frame is passed on or dropped. The receiver address is compared against a table of four programmable 6-byte addresses. Software, or a neighbouring register block, loads the table one byte at a time.

Frame summaries arrive on a valid/ready stream. The decision leaves on a second valid/ready stream one cycle after the frame is accepted. The output stage holds one decision. While that decision is waiting with `out_ready` low, `in_ready` is low and the upstream source must hold its frame. When the decision transfers in the same cycle, a new frame can be accepted, so back-to-back frames run at one per cycle.

Every dropped frame is charged to exactly one reason. Each reason has its own saturating 16-bit counter. The counter values are plain output pins.

Top module: `rxf_frame_filter`

## Requirements
- R1: A frame is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while a decision is held with `out_ready` low. After reset `in_ready` is high and `out_valid` is low.
- R2: The decision for an accepted frame appears on `out_valid` at the edge that accepts the frame, so it is visible in the next cycle. While `out_ready` is low, `out_valid`, `out_pass` and `out_reason` stay unchanged.
- R3: The address table has four slots of six bytes each. A write with `tbl_wr_en` high stores `tbl_wr_data` in byte `tbl_wr_byte` of slot `tbl_wr_slot`. A write with `tbl_wr_byte` of 6 or more is ignored. Byte k of a slot is compared with `in_addr1[8k+7:8k]`. Every byte of every slot is 0 after reset.
- R4: When `cfg_drop_addr` is high, a frame whose address equals no slot in all six bytes is dropped with reason 5. When `cfg_drop_addr` is low, the address never causes a drop.
- R5: When `cfg_drop_fcs` is high, a frame with `in_fcs_bad` high is dropped with reason 1. When `cfg_drop_fcs` is low, a bad checksum causes no drop.
- R6: When `cfg_drop_ctrl` is high, a frame with `in_is_ctrl` high is dropped with reason 4. When `cfg_drop_ctrl` is low, the control flag causes no drop.
- R7: A frame with `in_len` below MIN_LEN (default 14) is always dropped with reason 2. A frame with `in_len` above MAX_LEN (default 4095) is always dropped with reason 3. Lengths of exactly 14 and exactly 4095 pass the length rules.
- R8: When several rules hit, the reported reason follows this priority: checksum (1), then too short (2), then too long (3), then control (4), then address (5). Reason 0 means pass. `out_pass` is high exactly when `out_reason` is 0.
- R9: Each counter counts the drops of its own reason, is 0 after reset, grows by at most one per frame and stops at 0xFFFF.
- R10: A counter changes at the same edge at which the matching decision appears on the output. Each frame increments at most one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the counters |
| cfg_drop_fcs | input | 1 | Enable the drop rule for a bad checksum |
| cfg_drop_ctrl | input | 1 | Enable the drop rule for control frames |
| cfg_drop_addr | input | 1 | Enable the drop rule for an unmatched address |
| tbl_wr_en | input | 1 | Address table byte write strobe |
| tbl_wr_slot | input | 2 | Table slot to write |
| tbl_wr_byte | input | 3 | Byte index within the slot (0 to 5) |
| tbl_wr_data | input | 8 | Byte value to write |
| in_valid | input | 1 | Frame summary valid |
| in_ready | output | 1 | Filter can accept a frame summary |
| in_fcs_bad | input | 1 | Checksum of the frame failed |
| in_is_ctrl | input | 1 | Frame is of control type |
| in_len | input | 16 | Frame length in bytes |
| in_addr1 | input | 48 | Receiver address; byte k is bits 8k+7:8k |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Downstream takes the decision |
| out_pass | output | 1 | 1 = pass the frame, 0 = drop it |
| out_reason | output | 3 | 0 pass, 1 checksum, 2 short, 3 long, 4 control, 5 address |
| cnt_fcs | output | 16 | Drops for a bad checksum |
| cnt_short | output | 16 | Drops for a short length |
| cnt_long | output | 16 | Drops for a long length |
| cnt_ctrl | output | 16 | Drops of control frames |
| cnt_addr | output | 16 | Drops for an unmatched address |

## Verification
A decision and its counter increment are both due at the edge that accepts the frame. The decision then stays on the output until it is taken, so the scoreboard pops one expected reason per output transfer, in the middle of the cycle before the transfer edge. Directed checks sample `out_valid` and the affected counter just after the accepting edge. They also hold `out_ready` low for several cycles to confirm that the output stays unchanged and `in_ready` stays low. The counter totals are compared only after the pipeline has drained. At that point every increment has already been made, even for decisions that were held back.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Drop reasons; the numeric code is also the priority order (lower wins).
  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_FCS   = 3'd1,
    RSN_SHORT = 3'd2,
    RSN_LONG  = 3'd3,
    RSN_CTRL  = 3'd4,
    RSN_ADDR  = 3'd5
  } rxf_reason_e;

  localparam int NUM_REASONS = 5;
  localparam int REASON_W    = 3;

endpackage

// File: rtl/rxf_match_table.sv
module rxf_match_table #(
  parameter int SLOTS      = 4,
  parameter int ADDR_BYTES = 6,
  parameter int SLOT_W     = $clog2(SLOTS),
  parameter int BYTE_W     = $clog2(ADDR_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [BYTE_W-1:0]       wr_byte,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_BYTES*8-1:0] addr,
  output logic                    hit
);

  logic [SLOTS-1:0] slot_hit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [ADDR_BYTES-1:0] byte_eq;
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      logic [7:0] entry_q;
      logic       sel;
      assign sel = wr_en && (wr_slot == SLOT_W'(s)) && (wr_byte == BYTE_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   entry_q <= '0;
        else if (sel) entry_q <= wr_data;
      end
      assign byte_eq[b] = (entry_q == addr[8*b +: 8]);
    end
    assign slot_hit[s] = &byte_eq;
  end

  assign hit = |slot_hit;

endmodule

// File: rtl/rxf_rule_eval.sv
module rxf_rule_eval
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 4095
) (
  input  logic             drop_fcs,
  input  logic             drop_ctrl,
  input  logic             drop_addr,
  input  logic             fcs_bad,
  input  logic             is_ctrl,
  input  logic [LEN_W-1:0] len,
  input  logic             addr_hit,
  output rxf_reason_e      reason
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  always_comb begin
    if (drop_fcs && fcs_bad)        reason = RSN_FCS;
    else if (len < MIN_L)           reason = RSN_SHORT;
    else if (len > MAX_L)           reason = RSN_LONG;
    else if (drop_ctrl && is_ctrl)  reason = RSN_CTRL;
    else if (drop_addr && !addr_hit) reason = RSN_ADDR;
    else                            reason = RSN_NONE;
  end

endmodule

// File: rtl/rxf_sat_counter.sv
module rxf_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (inc && (count != '1)) count <= count + 1'b1;
  end

endmodule

// File: rtl/rxf_frame_filter.sv
module rxf_frame_filter
  import rxf_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 16,
  parameter int MIN_LEN    = 14,
  parameter int MAX_LEN    = 4095,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int BYTE_W    = $clog2(ADDR_BYTES),
  localparam int ADDR_W    = ADDR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_drop_fcs,
  input  logic              cfg_drop_ctrl,
  input  logic              cfg_drop_addr,
  input  logic              tbl_wr_en,
  input  logic [SLOT_W-1:0] tbl_wr_slot,
  input  logic [BYTE_W-1:0] tbl_wr_byte,
  input  logic [7:0]        tbl_wr_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_fcs_bad,
  input  logic              in_is_ctrl,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [ADDR_W-1:0] in_addr1,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_pass,
  output logic [REASON_W-1:0] out_reason,
  output logic [CNT_W-1:0]  cnt_fcs,
  output logic [CNT_W-1:0]  cnt_short,
  output logic [CNT_W-1:0]  cnt_long,
  output logic [CNT_W-1:0]  cnt_ctrl,
  output logic [CNT_W-1:0]  cnt_addr
);

  logic        addr_hit;
  rxf_reason_e reason_d;
  logic        accept;
  logic        valid_q;
  logic        pass_q;
  rxf_reason_e reason_q;
  logic [CNT_W-1:0] cnt_vec [NUM_REASONS];

  rxf_match_table #(
    .SLOTS(SLOTS), .ADDR_BYTES(ADDR_BYTES)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_slot(tbl_wr_slot), .wr_byte(tbl_wr_byte),
    .wr_data(tbl_wr_data), .addr(in_addr1), .hit(addr_hit)
  );

  rxf_rule_eval #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_rules (
    .drop_fcs(cfg_drop_fcs), .drop_ctrl(cfg_drop_ctrl), .drop_addr(cfg_drop_addr),
    .fcs_bad(in_fcs_bad), .is_ctrl(in_is_ctrl), .len(in_len),
    .addr_hit(addr_hit), .reason(reason_d)
  );

  // Single-entry output stage: free when empty or being drained this cycle.
  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      pass_q   <= 1'b0;
      reason_q <= RSN_NONE;
    end else if (accept) begin
      valid_q  <= 1'b1;
      pass_q   <= (reason_d == RSN_NONE);
      reason_q <= reason_d;
    end else if (out_ready) begin
      valid_q  <= 1'b0;
    end
  end

  // One saturating counter per drop reason; index i counts reason code i+1.
  for (genvar i = 0; i < NUM_REASONS; i++) begin : g_cnt
    logic hit_i;
    assign hit_i = accept && (reason_d == rxf_reason_e'(i + 1));
    rxf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(hit_i), .count(cnt_vec[i])
    );
  end

  assign out_valid  = valid_q;
  assign out_pass   = pass_q;
  assign out_reason = reason_q;
  assign cnt_fcs    = cnt_vec[0];
  assign cnt_short  = cnt_vec[1];
  assign cnt_long   = cnt_vec[2];
  assign cnt_ctrl   = cnt_vec[3];
  assign cnt_addr   = cnt_vec[4];

endmodule

// File: rtl/rxf_frame_filter_chk.sv
module rxf_frame_filter_chk #(
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_drop_fcs,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_fcs_bad,
  input logic [LEN_W-1:0] in_len,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_pass,
  input logic [2:0]       out_reason,
  input logic [CNT_W-1:0] cnt_fcs,
  input logic [CNT_W-1:0] cnt_short,
  input logic [CNT_W-1:0] cnt_long,
  input logic [CNT_W-1:0] cnt_ctrl,
  input logic [CNT_W-1:0] cnt_addr
);

  AST_DECISION_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R2
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_reason) && $stable(out_pass))); // R2
  AST_FCS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_drop_fcs && in_fcs_bad) |=> (out_reason == 3'd1 && !out_pass)); // R8
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(cfg_drop_fcs && in_fcs_bad) && (in_len < LEN_W'(MIN_LEN)))
      |=> (out_reason == 3'd2 && !out_pass)); // R7
  AST_ONE_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cnt_fcs != $past(cnt_fcs), cnt_short != $past(cnt_short),
                cnt_long != $past(cnt_long), cnt_ctrl != $past(cnt_ctrl),
                cnt_addr != $past(cnt_addr)}) <= 1); // R10
  AST_STEP_FCS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fcs == $past(cnt_fcs)) || ({1'b0, cnt_fcs} == {1'b0, $past(cnt_fcs)} + 1'b1)); // R9
  AST_STEP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_short == $past(cnt_short)) || ({1'b0, cnt_short} == {1'b0, $past(cnt_short)} + 1'b1)); // R9
  AST_STEP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_long == $past(cnt_long)) || ({1'b0, cnt_long} == {1'b0, $past(cnt_long)} + 1'b1)); // R9
  AST_STEP_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ctrl == $past(cnt_ctrl)) || ({1'b0, cnt_ctrl} == {1'b0, $past(cnt_ctrl)} + 1'b1)); // R9
  AST_STEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_addr == $past(cnt_addr)) || ({1'b0, cnt_addr} == {1'b0, $past(cnt_addr)} + 1'b1)); // R9

endmodule

bind rxf_frame_filter rxf_frame_filter_chk #(
  .LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_drop_fcs(cfg_drop_fcs),
  .in_valid(in_valid), .in_ready(in_ready), .in_fcs_bad(in_fcs_bad), .in_len(in_len),
  .out_valid(out_valid), .out_ready(out_ready), .out_pass(out_pass), .out_reason(out_reason),
  .cnt_fcs(cnt_fcs), .cnt_short(cnt_short), .cnt_long(cnt_long),
  .cnt_ctrl(cnt_ctrl), .cnt_addr(cnt_addr)
);

// File: tb/rxf_frame_filter_tb.sv
`timescale 1ns/1ps
module rxf_frame_filter_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_drop_fcs = 0, cfg_drop_ctrl = 0, cfg_drop_addr = 0;
  logic tbl_wr_en = 0;
  logic [1:0] tbl_wr_slot = 0;
  logic [2:0] tbl_wr_byte = 0;
  logic [7:0] tbl_wr_data = 0;
  logic in_valid = 0, in_fcs_bad = 0, in_is_ctrl = 0;
  logic [15:0] in_len = 0;
  logic [47:0] in_addr1 = 0;
  logic out_ready = 1;
  logic in_ready, out_valid, out_pass;
  logic [2:0] out_reason;
  logic [15:0] cnt_fcs, cnt_short, cnt_long, cnt_ctrl, cnt_addr;

  always #10 clk = ~clk;

  rxf_frame_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_drop_fcs(cfg_drop_fcs), .cfg_drop_ctrl(cfg_drop_ctrl), .cfg_drop_addr(cfg_drop_addr),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_slot(tbl_wr_slot), .tbl_wr_byte(tbl_wr_byte),
    .tbl_wr_data(tbl_wr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_fcs_bad(in_fcs_bad),
    .in_is_ctrl(in_is_ctrl), .in_len(in_len), .in_addr1(in_addr1),
    .out_valid(out_valid), .out_ready(out_ready), .out_pass(out_pass), .out_reason(out_reason),
    .cnt_fcs(cnt_fcs), .cnt_short(cnt_short), .cnt_long(cnt_long),
    .cnt_ctrl(cnt_ctrl), .cnt_addr(cnt_addr)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] tab [4][6];
  int exp_cnt [6];
  logic [2:0] expq [$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] model(bit fcs, bit ctl, logic [15:0] len, logic [47:0] a);
    bit hit = 0;
    for (int s = 0; s < 4; s++) begin
      bit eq = 1;
      for (int b = 0; b < 6; b++) if (tab[s][b] != a[8*b +: 8]) eq = 0;
      if (eq) hit = 1;
    end
    if (cfg_drop_fcs && fcs) return 3'd1;
    if (len < 16'd14)        return 3'd2;
    if (len > 16'd4095)      return 3'd3;
    if (cfg_drop_ctrl && ctl) return 3'd4;
    if (cfg_drop_addr && !hit) return 3'd5;
    return 3'd0;
  endfunction

  // Driver: called just after a rising edge; returns just after the accepting edge.
  task automatic send(bit fcs, bit ctl, logic [15:0] len, logic [47:0] a);
    in_valid = 1; in_fcs_bad = fcs; in_is_ctrl = ctl; in_len = len; in_addr1 = a;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    expq.push_back(model(fcs, ctl, len, a));
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic wr_tab(int s, int b, logic [7:0] d);
    tbl_wr_en = 1; tbl_wr_slot = 2'(s); tbl_wr_byte = 3'(b); tbl_wr_data = d;
    @(posedge clk); #1;
    tbl_wr_en = 0;
    if (b < 6) tab[s][b] = d;
  endtask

  task automatic drain();
    while (expq.size() != 0 || out_valid) @(posedge clk);
    #1;
  endtask

  task automatic chk_counts(string req);
    chk(cnt_fcs == 16'(exp_cnt[1]), req, "cnt_fcs", cnt_fcs, exp_cnt[1]);
    chk(cnt_short == 16'(exp_cnt[2]), req, "cnt_short", cnt_short, exp_cnt[2]);
    chk(cnt_long == 16'(exp_cnt[3]), req, "cnt_long", cnt_long, exp_cnt[3]);
    chk(cnt_ctrl == 16'(exp_cnt[4]), req, "cnt_ctrl", cnt_ctrl, exp_cnt[4]);
    chk(cnt_addr == 16'(exp_cnt[5]), req, "cnt_addr", cnt_addr, exp_cnt[5]);
  endtask

  // Monitor: a transfer happens at the next rising edge when both are high here.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R2", "unexpected decision", out_reason, 0);
      end else begin
        logic [2:0] e;
        e = expq.pop_front();
        chk(out_reason == e, "R8", "out_reason", out_reason, e);
        chk(out_pass == (e == 3'd0), "R8", "out_pass", out_pass, e == 3'd0);
        if (e != 0 && exp_cnt[e] < 65535) exp_cnt[e]++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  localparam logic [47:0] ADDR_A = 48'h5A_4B_3C_2D_1E_0F;

  initial begin
    for (int s = 0; s < 4; s++) for (int b = 0; b < 6; b++) tab[s][b] = 0;
    for (int i = 0; i < 6; i++) exp_cnt[i] = 0;
    repeat (3) @(posedge clk); #1;
    // R1 / R9: reset state
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk_counts("R9");
    rst_n = 1;
    @(posedge clk); #1;

    // R5 / R6 / R4: rules disabled do nothing
    send(1, 1, 16'd100, 48'h1234);
    chk(out_valid == 1 && out_reason == 0, "R5", "fcs/ctrl/addr disabled pass", out_reason, 0);
    // R10: counter unchanged for a pass, checked with the decision
    chk(cnt_fcs == 0, "R10", "no charge on pass", cnt_fcs, 0);

    // R3: table resets to zero, so address zero matches
    cfg_drop_addr = 1;
    send(0, 0, 16'd64, 48'h0);
    send(0, 0, 16'd64, ADDR_A);               // R4 mismatch
    drain();
    chk(cnt_addr == 1, "R4", "addr mismatch counted", cnt_addr, 1);

    // R3: byte-wise programming of slot 2; byte write 6 ignored
    for (int b = 0; b < 6; b++) wr_tab(2, b, ADDR_A[8*b +: 8]);
    wr_tab(2, 6, 8'hFF);
    send(0, 0, 16'd64, ADDR_A);               // R3 match -> pass
    send(0, 0, 16'd64, ADDR_A ^ 48'h01_00_00_00_00_00); // R4 byte 5 differs
    wr_tab(3, 0, 8'h77);
    send(0, 0, 16'd64, 48'h77);               // R3 slot 3 only byte0 set -> match
    drain();

    // R6 / R5 enabled
    cfg_drop_ctrl = 1; cfg_drop_fcs = 1;
    send(0, 1, 16'd200, ADDR_A);              // R6
    send(1, 0, 16'd200, ADDR_A);              // R5
    // R10: counter changes together with the decision
    chk(out_reason == 1 && cnt_fcs == 1, "R10", "cnt_fcs with decision", cnt_fcs, 1);

    // R7 boundaries
    send(0, 0, 16'd13, ADDR_A);
    send(0, 0, 16'd14, ADDR_A);
    send(0, 0, 16'd4095, ADDR_A);
    send(0, 0, 16'd4096, ADDR_A);
    send(0, 0, 16'd0, ADDR_A);
    send(0, 0, 16'hFFFF, ADDR_A);

    // R8 priority
    send(1, 1, 16'd5, 48'h9);     // fcs wins
    send(0, 1, 16'd5, 48'h9);     // short over ctrl/addr
    send(0, 1, 16'd5000, 48'h9);  // long over ctrl/addr
    send(0, 1, 16'd100, 48'h9);   // ctrl over addr
    drain();
    chk_counts("R9");

    // R1 / R2: back-pressure
    out_ready = 0;
    send(0, 0, 16'd3, ADDR_A);
    chk(out_valid == 1, "R2", "decision one cycle after accept", out_valid, 1);
    in_valid = 1; in_len = 16'd100;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready == 0, "R1", "in_ready low while stalled", in_ready, 0);
      chk(out_valid == 1 && out_reason == 2, "R2", "held decision", out_reason, 2);
    end
    @(posedge clk); #1;
    in_valid = 0;
    out_ready = 1;
    drain();
    chk(in_ready == 1, "R1", "in_ready after drain", in_ready, 1);

    // R9: saturation with back-to-back short frames
    for (int n = 0; n < 65540; n++) send(0, 0, 16'd1, ADDR_A);
    drain();
    chk(cnt_short == 16'hFFFF, "R9", "cnt_short saturates", cnt_short, 16'hFFFF);
    chk_counts("R9");

    // R9: reset clears counters
    @(posedge clk); #1;
    rst_n = 0;
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) exp_cnt[i] = 0;
    chk_counts("R9");
    rst_n = 1;
    @(posedge clk); #1;
    finish_run();
  end

endmodule